// File: doc/BRIEF.md
# Recalled Image Priority Scorer and Selector

This block takes a batch of candidate images that arrive together after a successful memory lookup and chooses the one that matters most. Each candidate register holds an image word and a fixed number of unsigned importance weights. On a single load pulse every register captures its image, its weights and a valid flag. A shared sequencer then steps all registers in lockstep. Each register keeps a running sum that starts from its first weight and takes in one more weight per step.

When the last weight has been added, a magnitude compare over the valid registers picks the largest total. Equal totals go to the lowest register index. The block registers the winning index, the winning image and its total, and raises a one-cycle done pulse. The winning image can then be written into a short-term store. If no register was flagged valid, the done pulse comes with a no-result flag and the result fields are zero. A load pulse that arrives while scoring is under way is dropped.

Top module: `recall_priority_select`

## Requirements
- R1: A load pulse is accepted only when the block is idle, and that includes the cycle in which done is high. A load pulse during scoring has no effect: the result reported is that of the earlier load, and no extra done pulse follows.
- R2: The total of a register is the exact unsigned sum of all its NFIELD weights. The total is NW + ceil(log2 NFIELD) bits wide and never overflows. Weight i of register r sits at bits [(r*NFIELD+i)*NW +: NW] of `wt_i`, and weight 0 is the one the sum starts from.
- R3: The sum starts from weight 0 at the load edge and takes one more weight per clock over NFIELD−1 steps. The compare follows one clock later, so `done_o` is high in the cycle that begins NFIELD clock edges after the edge that accepted the load.
- R4: `done_o` is high for exactly one cycle per accepted load.
- R5: When at least one register is valid, `win_idx_o` and `win_sum_o` report a valid register whose total is the largest of all valid totals.
- R6: When several valid registers share the largest total, the lowest index wins.
- R7: Registers whose bit in `valid_i` was 0 at load time never win, whatever their weights.
- R8: With no valid register, `none_o` is 1 in the done cycle and `win_idx_o`, `win_img_o` and `win_sum_o` are 0. With a winner, `none_o` is 0.
- R9: `win_idx_o`, `win_img_o`, `win_sum_o` and `none_o` hold their values from one done pulse until the next.
- R10: After reset, `done_o`, `none_o` and all result outputs are 0.
- R11: `win_img_o` equals the image word that the winning register captured, taken from bits [r*IMG_W +: IMG_W] of `img_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle pulse that loads all candidate registers |
| valid_i | input | NREG | Per-register flag that the candidate takes part |
| img_i | input | NREG*IMG_W | Image words, register r at [r*IMG_W +: IMG_W] |
| wt_i | input | NREG*NFIELD*NW | Importance weights, packed as in R2 |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| none_o | output | 1 | No valid candidate in the last batch |
| win_idx_o | output | max(1,ceil(log2 NREG)) | Index of the winning register |
| win_img_o | output | IMG_W | Image word of the winner |
| win_sum_o | output | NW+ceil(log2 NFIELD) | Total of the winner |

## Verification
The bench uses the default build: four registers, five 4-bit weights each, 16-bit images and a 7-bit total. With five weights the running sum goes through four real steps. All-maximum weights reach a total of 75, which fills the upper bits of the total without overflow. Four lanes are enough to place ties at non-adjacent indices, to hide a lane with maximum weights behind a cleared valid bit, and to leave only the top index valid. Each of these cases is directed, and they are mixed with seeded random weights and random valid masks.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACC  = 2'd1,
    SEQ_CMP  = 2'd2
  } seq_state_e;

  // Width that holds nf unsigned values of ww bits without overflow.
  function automatic int total_width(int ww, int nf);
    return ww + $clog2(nf);
  endfunction

  // Width of a register index, never below one bit.
  function automatic int index_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rps_seq.sv
module rps_seq
  import rps_pkg::*;
#(
  parameter int NFIELD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic cap_o,
  output logic step_o,
  output logic cmp_o
);

  localparam int CW = (NFIELD > 2) ? $clog2(NFIELD - 1) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(NFIELD - 2);

  seq_state_e state_q;
  logic [CW-1:0] step_cnt_q;

  assign cap_o  = (state_q == SEQ_IDLE) && load_i;
  assign step_o = (state_q == SEQ_ACC);
  assign cmp_o  = (state_q == SEQ_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      step_cnt_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (load_i) begin
            state_q    <= SEQ_ACC;
            step_cnt_q <= '0;
          end
        end
        SEQ_ACC: begin
          if (step_cnt_q == LAST_STEP) begin
            state_q <= SEQ_CMP;
          end
          step_cnt_q <= step_cnt_q + 1'b1;
        end
        SEQ_CMP: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R1: an accepted load puts the sequencer in the busy state, so no second capture can follow at once
  a_r1_no_back_to_back_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);

  // R3: the compare slot comes right after the last accumulate step
  a_r3_cmp_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_o |-> $past(step_o));

  // R3: the three phases never overlap
  a_r3_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_o, step_o, cmp_o}));

endmodule

// File: rtl/rps_lane.sv
module rps_lane #(
  parameter int NFIELD = 5,
  parameter int NW     = 4,
  parameter int IMG_W  = 16,
  parameter int SW     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_i,
  input  logic                 step_i,
  input  logic                 valid_i,
  input  logic [IMG_W-1:0]     img_i,
  input  logic [NFIELD*NW-1:0] wt_i,
  output logic                 valid_o,
  output logic [IMG_W-1:0]     img_o,
  output logic [SW-1:0]        sum_o
);

  localparam int NPEND = NFIELD - 1;

  // Running sum absorbs one zero-extended weight.
  function automatic logic [SW-1:0] absorb(logic [SW-1:0] acc, logic [NW-1:0] w);
    return acc + SW'(w);
  endfunction

  logic [SW-1:0]    acc_q;
  logic [NW-1:0]    pend_q [NPEND];
  logic             valid_q;
  logic [IMG_W-1:0] img_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      valid_q <= 1'b0;
      img_q   <= '0;
    end else if (cap_i) begin
      acc_q   <= SW'(wt_i[NW-1:0]);
      valid_q <= valid_i;
      img_q   <= img_i;
    end else if (step_i) begin
      acc_q <= absorb(acc_q, pend_q[0]);
    end
  end

  // Pending weights, head entry is the next one to absorb.
  for (genvar j = 0; j < NPEND; j++) begin : g_pend
    if (j == NPEND - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)      pend_q[j] <= '0;
        else if (cap_i)  pend_q[j] <= wt_i[(j+1)*NW +: NW];
        else if (step_i) pend_q[j] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n)      pend_q[j] <= '0;
        else if (cap_i)  pend_q[j] <= wt_i[(j+1)*NW +: NW];
        else if (step_i) pend_q[j] <= pend_q[j+1];
      end
    end
  end

  assign valid_o = valid_q;
  assign img_o   = img_q;
  assign sum_o   = acc_q;

  // R2: adding the head weight never carries out of the total width
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((({1'b0, acc_q} + {1'b0, SW'(pend_q[0])}) >> SW) == '0));

  // R2: the total only grows while stepping
  a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (acc_q >= $past(acc_q)));

  // R9: captured state is frozen outside load and step
  a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && !step_i) |=> ($stable(acc_q) && $stable(img_q) && $stable(valid_q)));

endmodule

// File: rtl/rps_max.sv
module rps_max
  import rps_pkg::*;
#(
  parameter int NREG = 4,
  parameter int SW   = 7
) (
  input  logic [NREG-1:0]    valid_i,
  input  logic [NREG*SW-1:0] sums_i,
  output logic               found_o,
  output logic [index_width(NREG)-1:0] idx_o,
  output logic [SW-1:0]      sum_o
);

  localparam int IW = index_width(NREG);

  // A later lane replaces the current best only on a strictly larger total.
  function automatic logic takes_over(logic have, logic [SW-1:0] best, logic [SW-1:0] cand);
    return !have || (cand > best);
  endfunction

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    sum_o   = '0;
    for (int r = 0; r < NREG; r++) begin
      if (valid_i[r] && takes_over(found_o, sum_o, sums_i[r*SW +: SW])) begin
        found_o = 1'b1;
        idx_o   = IW'(r);
        sum_o   = sums_i[r*SW +: SW];
      end
    end
  end

endmodule

// File: rtl/recall_priority_select.sv
module recall_priority_select
  import rps_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int NFIELD = 5,
  parameter int NW     = 4,
  parameter int IMG_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load_i,
  input  logic [NREG-1:0]                     valid_i,
  input  logic [NREG*IMG_W-1:0]               img_i,
  input  logic [NREG*NFIELD*NW-1:0]           wt_i,
  output logic                                done_o,
  output logic                                none_o,
  output logic [index_width(NREG)-1:0]        win_idx_o,
  output logic [IMG_W-1:0]                    win_img_o,
  output logic [total_width(NW, NFIELD)-1:0]  win_sum_o
);

  localparam int SW  = total_width(NW, NFIELD);
  localparam int IW  = index_width(NREG);
  localparam int LW  = $clog2(NFIELD + 2) + 1;
  localparam logic [LW-1:0] LAT_DONE = LW'(NFIELD + 1);

  // Internal events, named for the checks below.
  logic cap_ev, step_ev, cmp_ev;

  logic [NREG-1:0]       lane_valid;
  logic [NREG*SW-1:0]    lane_sums;
  logic [IMG_W-1:0]      lane_img [NREG];

  logic                  sel_found;
  logic [IW-1:0]         sel_idx;
  logic [SW-1:0]         sel_sum;
  logic [IMG_W-1:0]      sel_img;

  rps_seq #(.NFIELD(NFIELD)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .cap_o  (cap_ev),
    .step_o (step_ev),
    .cmp_o  (cmp_ev)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_lane
    rps_lane #(.NFIELD(NFIELD), .NW(NW), .IMG_W(IMG_W), .SW(SW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap_ev),
      .step_i  (step_ev),
      .valid_i (valid_i[r]),
      .img_i   (img_i[r*IMG_W +: IMG_W]),
      .wt_i    (wt_i[r*NFIELD*NW +: NFIELD*NW]),
      .valid_o (lane_valid[r]),
      .img_o   (lane_img[r]),
      .sum_o   (lane_sums[r*SW +: SW])
    );
  end

  rps_max #(.NREG(NREG), .SW(SW)) u_max (
    .valid_i (lane_valid),
    .sums_i  (lane_sums),
    .found_o (sel_found),
    .idx_o   (sel_idx),
    .sum_o   (sel_sum)
  );

  // Route the winning lane's image.
  always_comb begin
    sel_img = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel_found && (sel_idx == IW'(r))) sel_img = lane_img[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      none_o    <= 1'b0;
      win_idx_o <= '0;
      win_img_o <= '0;
      win_sum_o <= '0;
    end else begin
      done_o <= cmp_ev;
      if (cmp_ev) begin
        none_o    <= !sel_found;
        win_idx_o <= sel_idx;
        win_img_o <= sel_img;
        win_sum_o <= sel_sum;
      end
    end
  end

  // Cycles since the last accepted load, for the latency check.
  logic [LW-1:0] since_cap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                         since_cap_q <= '0;
    else if (cap_ev)                    since_cap_q <= LW'(1);
    else if (since_cap_q != '0 && since_cap_q != '1) since_cap_q <= since_cap_q + 1'b1;
  end

  // Any valid lane whose total beats the reported one.
  logic beaten;
  logic winner_valid;
  always_comb begin
    beaten       = 1'b0;
    winner_valid = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (lane_valid[r] && (lane_sums[r*SW +: SW] > win_sum_o)) beaten = 1'b1;
      if ((win_idx_o == IW'(r)) && lane_valid[r]) winner_valid = 1'b1;
    end
  end

  // R3: done arrives NFIELD edges after the capturing edge
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (since_cap_q == LAT_DONE));

  // R4: a single-cycle done
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: no valid lane exceeds the reported total
  a_r5_winner_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !none_o) |-> !beaten);

  // R7: the reported lane was flagged valid at load
  a_r7_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !none_o) |-> winner_valid);

  // R8: an empty batch reports zeros
  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && none_o) |-> (win_idx_o == '0 && win_sum_o == '0 && win_img_o == '0 && lane_valid == '0));

  // R9: results hold between done pulses
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ev |=> ($stable(win_sum_o) && $stable(win_idx_o) && $stable(win_img_o) && $stable(none_o)));

endmodule

// File: tb/recall_priority_select_bench.sv
module recall_priority_select_bench;

  localparam int NREG   = 4;
  localparam int NFIELD = 5;
  localparam int NW     = 4;
  localparam int IMG_W  = 16;
  localparam int SW     = NW + $clog2(NFIELD);
  localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [NREG-1:0] valid_i = '0;
  logic [NREG*IMG_W-1:0] img_i = '0;
  logic [NREG*NFIELD*NW-1:0] wt_i = '0;
  logic done_o, none_o;
  logic [IW-1:0] win_idx_o;
  logic [IMG_W-1:0] win_img_o;
  logic [SW-1:0] win_sum_o;

  always #4 clk = ~clk;

  recall_priority_select #(.NREG(NREG), .NFIELD(NFIELD), .NW(NW), .IMG_W(IMG_W)) u_recall_priority_select (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .valid_i(valid_i), .img_i(img_i), .wt_i(wt_i),
    .done_o(done_o), .none_o(none_o), .win_idx_o(win_idx_o), .win_img_o(win_img_o), .win_sum_o(win_sum_o)
  );

  int total = 0;
  int fails = 0;

  int wt [NREG][NFIELD];
  int im [NREG];
  logic [NREG-1:0] vm;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_total(int r);
    int s = 0;
    foreach (wt[r][i]) s += wt[r][i];
    return s;
  endfunction

  // Expected winner: -1 for none, otherwise lowest index among the largest totals.
  function automatic int ref_winner();
    int best = -1;
    int bsum = -1;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (vm[r] && lane_total(r) >= bsum) begin
        best = r;
        bsum = lane_total(r);
      end
    end
    return best;
  endfunction

  task automatic drive_batch();
    for (int r = 0; r < NREG; r++) begin
      img_i[r*IMG_W +: IMG_W] = IMG_W'(im[r]);
      for (int i = 0; i < NFIELD; i++) wt_i[(r*NFIELD+i)*NW +: NW] = NW'(wt[r][i]);
    end
    valid_i = vm;
  endtask

  task automatic wait_done(output int waited);
    waited = 1;
    while (!done_o && waited < 60) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic check_result(input string tag);
    int w = ref_winner();
    chk(done_o == 1'b1, {"R4 done ", tag}, int'(done_o), 1);
    if (w < 0) begin
      chk(none_o == 1'b1, {"R8 none ", tag}, int'(none_o), 1);
      chk(win_sum_o == '0 && win_idx_o == '0 && win_img_o == '0, {"R8 zero ", tag}, int'(win_sum_o), 0);
    end else begin
      chk(none_o == 1'b0, {"R8 none ", tag}, int'(none_o), 0);
      chk(int'(win_idx_o) == w, {"R5 R6 R7 idx ", tag}, int'(win_idx_o), w);
      chk(int'(win_sum_o) == lane_total(w), {"R2 sum ", tag}, int'(win_sum_o), lane_total(w));
      chk(int'(win_img_o) == im[w], {"R11 img ", tag}, int'(win_img_o), im[w]);
    end
  endtask

  task automatic run_case(input string tag);
    int waited;
    logic [SW-1:0] s_hold;
    @(negedge clk);
    drive_batch();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    wait_done(waited);
    chk(waited == NFIELD + 1, {"R3 latency ", tag}, waited, NFIELD + 1);
    check_result(tag);
    s_hold = win_sum_o;
    @(negedge clk);
    chk(done_o == 1'b0, {"R4 one cycle ", tag}, int'(done_o), 0);
    repeat (2) @(negedge clk);
    chk(win_sum_o == s_hold, {"R9 hold ", tag}, int'(win_sum_o), int'(s_hold));
  endtask

  task automatic fill_random();
    for (int r = 0; r < NREG; r++) begin
      im[r] = int'($urandom_range(0, 65535));
      for (int i = 0; i < NFIELD; i++) wt[r][i] = int'($urandom_range(0, (1 << NW) - 1));
    end
    vm = NREG'($urandom_range(0, (1 << NREG) - 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int waited;
    int saw_done;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done_o == 0 && none_o == 0 && win_sum_o == 0 && win_idx_o == 0 && win_img_o == 0,
        "R10 reset", int'(win_sum_o), 0);
    rst_n = 1'b1;

    // R2 R6: every weight at maximum, all lanes tie at 75
    for (int r = 0; r < NREG; r++) begin
      im[r] = 16'h1000 + r;
      for (int i = 0; i < NFIELD; i++) wt[r][i] = (1 << NW) - 1;
    end
    vm = '1;
    run_case("all max tie");

    // R6 R7: lanes 1 and 3 tie, lanes 0 and 2 invalid and larger
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NFIELD; i++) wt[r][i] = (r % 2 == 0) ? 15 : i + 1;
    vm = 4'b1010;
    run_case("tie odd lanes");

    // R7: lane 0 invalid with maximum weights
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NFIELD; i++) wt[r][i] = (r == 0) ? 15 : r;
    vm = 4'b1110;
    run_case("hidden max");

    // R5: only the top lane valid
    vm = 4'b1000;
    run_case("top only");

    // R8: empty batch
    vm = '0;
    run_case("none valid");

    // R2: weight order irrelevant, unique maximum only in the last field
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NFIELD; i++) wt[r][i] = (i == NFIELD - 1) ? r * 3 : 1;
    vm = '1;
    run_case("last field decides");

    // R1: second load during scoring is dropped
    for (int r = 0; r < NREG; r++) begin
      im[r] = 16'hA000 + r;
      for (int i = 0; i < NFIELD; i++) wt[r][i] = (r == 2) ? 9 : 2;
    end
    vm = '1;
    @(negedge clk);
    drive_batch();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    @(negedge clk);
    valid_i = 4'b0001;
    wt_i = '1;
    img_i = '0;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    waited = 3;
    while (!done_o && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    chk(waited == NFIELD + 1, "R1 R3 latency with busy load", waited, NFIELD + 1);
    check_result("busy load");
    saw_done = 0;
    repeat (NFIELD + 3) begin
      @(negedge clk);
      if (done_o) saw_done++;
    end
    chk(saw_done == 0, "R1 no extra done", saw_done, 0);

    // R1: load in the done cycle is accepted
    fill_random();
    vm = 4'b0110;
    run_case("pre back to back");
    for (int r = 0; r < NREG; r++) im[r] = 16'h5500 + r;
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NFIELD; i++) wt[r][i] = r + i;
    vm = '1;
    @(negedge clk);
    drive_batch();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    wait_done(waited);
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NFIELD; i++) wt[r][i] = 14 - r - i;
    drive_batch();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    wait_done(waited);
    chk(waited == NFIELD + 1, "R1 load in done cycle", waited, NFIELD + 1);
    check_result("done cycle load");

    // random batches
    for (int n = 0; n < 40; n++) begin
      fill_random();
      run_case($sformatf("random %0d", n));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule